// File: doc/BRIEF.md
# Serial Character Match Detector

This block watches an asynchronous serial line that carries 8-bit characters, least significant bit first, with a single stop bit and no parity. It raises a one-cycle pulse when one particular character, fixed by a parameter, has arrived with a valid stop bit. The received byte is never collected in a register. A four-state controller instead compares each bit against the matching bit of the trigger pattern at the moment that bit is sampled.

The block runs on an oversampling clock whose ratio to the bit rate is a parameter. The serial input passes through a two-stage synchronizer first. A start bit is accepted only if the line stays low until the middle of that bit, so short low glitches are ignored. Once a data bit fails to match, the controller keeps timing the rest of the frame and still checks the stop bit. A low stop bit raises a framing-error flag, and the flag stays up until the line is seen high again at a later bit centre.

Top module: `sermatch_top`

## Requirements
- R1: After reset, `match_o` and `ferr_o` are low, and the block waits for a start bit with the line idle high.
- R2: A start bit counts only after the synchronized line has been low for OVS/2 consecutive oversample cycles. A shorter low pulse is ignored, the block stays idle, and the next real frame is received normally.
- R3: Data bits are sampled at their centres, one bit time (OVS cycles) apart, least significant bit first. Data bit k is compared with bit k of TRIGGER. A byte that differs in any single position, or the bit-reversed trigger byte, produces no match.
- R4: When the trigger byte arrives followed by a high stop bit, `match_o` is high for exactly one clock cycle, and only once per frame.
- R5: After a data mismatch, the block keeps timing bit periods up to the stop-bit position. Falling edges inside the rest of the frame are not taken as start bits. A frame that starts right after the stop bit is received correctly.
- R6: A low stop bit gives no match pulse and sets `ferr_o`. The flag stays set until the line is sampled high at a following bit centre. The block then returns to idle and clears `ferr_o`. This holds for both matching and mismatching data.
- R7: The internal bit counter never exceeds 9, and the all-bits-matched state is entered only with the counter at the stop position (8).
- R8: Frames sent back to back (stop bit directly followed by the next start bit) are each evaluated, and each trigger frame gives its own pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, OVS cycles per bit |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| match_o | output | 1 | One-cycle pulse when the trigger character is received |
| ferr_o | output | 1 | Framing error: the stop bit was sampled low |

## Verification
Several properties are checked on every cycle: the match pulse lasts one cycle, a match and a framing error never occur together, the bit counter stays bounded, the matched state only appears at the stop position, the controller never leaves the wait state before the stop position, and the baud counter stays in range with ticks never on consecutive cycles. Some behaviour can only be shown by the bench's scenarios, because it depends on whole frames on the line: rejecting short glitches, the LSB-first per-bit comparison, ignoring edges after a mismatch, how long the error flag is held and when it clears, and back-to-back reception.

// File: rtl/sermatch_pkg.sv
package sermatch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2,
    ST_OK   = 2'd3
  } mstate_e;

  localparam int unsigned DATA_BITS = 8;
  localparam logic [3:0]  LAST_IDX  = 4'd7;
  localparam logic [3:0]  STOP_IDX  = 4'd8;
  localparam logic [3:0]  ERR_IDX   = 4'd9;

  // Counter preset that makes the idle countdown last ovs/2 cycles
  function automatic int unsigned half_preset(input int unsigned ovs);
    return (ovs / 2) - 1;
  endfunction

  // Pattern bit expected at data position idx (LSB first)
  function automatic logic pattern_bit(input logic [7:0] trig, input logic [3:0] idx);
    return trig[idx[2:0]];
  endfunction

endpackage

// File: rtl/sermatch_sync.sv
module sermatch_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], async_i};
  end

  assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/sermatch_baud.sv
module sermatch_baud
  import sermatch_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic idle_i,
  output logic tick_o
);
  localparam int unsigned CW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] FULL  = CW'(OVS - 1);
  localparam logic [CW-1:0] HALFP = CW'(half_preset(OVS));

  logic [CW-1:0] cnt;
  logic          hold;

  assign hold   = idle_i & line_i;
  assign tick_o = (cnt == '0) & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= HALFP;
    else if (hold)        cnt <= HALFP;
    else if (cnt == '0)   cnt <= FULL;
    else                  cnt <= cnt - 1'b1;
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL);
  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n) tick_o |=> !tick_o);
endmodule

// File: rtl/sermatch_fsm.sv
module sermatch_fsm
  import sermatch_pkg::*;
#(
  parameter logic [7:0] TRIGGER = 8'h4B
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic tick_i,
  output logic idle_o,
  output logic match_o,
  output logic ferr_o
);
  mstate_e    state, state_n;
  logic [3:0] idx, idx_n;
  logic       match_q, match_n;
  logic       ferr_q, ferr_n;

  logic want_bit, bit_ok, at_stop, last_data;

  assign want_bit  = pattern_bit(TRIGGER, idx);
  assign bit_ok    = (line_i == want_bit);
  assign at_stop   = (idx >= STOP_IDX);
  assign last_data = (idx == LAST_IDX);

  always_comb begin
    state_n = state;
    idx_n   = idx;
    ferr_n  = ferr_q;
    match_n = 1'b0;
    if (tick_i) begin
      unique case (state)
        ST_IDLE: begin
          state_n = ST_RUN;
          idx_n   = 4'd0;
        end
        ST_RUN: begin
          idx_n = idx + 4'd1;
          if (!bit_ok)        state_n = ST_WAIT;
          else if (last_data) state_n = ST_OK;
        end
        default: begin
          if (!at_stop) begin
            idx_n = idx + 4'd1;
          end else if (line_i) begin
            state_n = ST_IDLE;
            idx_n   = 4'd0;
            ferr_n  = 1'b0;
            match_n = (state == ST_OK) && (idx == STOP_IDX);
          end else begin
            state_n = ST_WAIT;
            idx_n   = ERR_IDX;
            ferr_n  = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx     <= 4'd0;
      match_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state   <= state_n;
      idx     <= idx_n;
      match_q <= match_n;
      ferr_q  <= ferr_n;
    end
  end

  assign idle_o  = (state == ST_IDLE);
  assign match_o = match_q;
  assign ferr_o  = ferr_q;

  // R4
  match_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) match_q |=> !match_q);
  // R6
  match_ferr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(match_q && ferr_q));
  // R6
  ferr_idx_chk: assert property (@(posedge clk) disable iff (!rst_n) ferr_q |-> (idx == ERR_IDX));
  // R7
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) idx <= ERR_IDX);
  // R7
  ok_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_OK) |-> (idx == STOP_IDX));
  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                                  (state == ST_WAIT && idx < STOP_IDX) |=> (state == ST_WAIT));
endmodule

// File: rtl/sermatch_top.sv
module sermatch_top
  import sermatch_pkg::*;
#(
  parameter logic [7:0]  TRIGGER = 8'h4B,
  parameter int unsigned OVS     = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic match_o,
  output logic ferr_o
);
  logic line_s;
  logic tick;
  logic idle;

  sermatch_sync #(.STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(rx_i), .sync_o(line_s)
  );

  sermatch_baud #(.OVS(OVS)) baud_i (
    .clk(clk), .rst_n(rst_n), .line_i(line_s), .idle_i(idle), .tick_o(tick)
  );

  sermatch_fsm #(.TRIGGER(TRIGGER)) fsm_i (
    .clk(clk), .rst_n(rst_n), .line_i(line_s), .tick_i(tick),
    .idle_o(idle), .match_o(match_o), .ferr_o(ferr_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> (!match_o && !ferr_o));
endmodule

// File: tb/sermatch_top_tb_top.sv
`timescale 1ns/1ps
module sermatch_top_tb_top;
  localparam logic [7:0]  TRIG = 8'h4B;
  localparam int unsigned OVS  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic match_o, ferr_o;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int wide   = 0;
  logic prev_m = 1'b0;

  always #5 clk = ~clk;

  sermatch_top #(.TRIGGER(TRIG), .OVS(OVS)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .match_o(match_o), .ferr_o(ferr_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (match_o) pulses++;
      if (match_o && prev_m) wide++;
      prev_m <= match_o;
    end
  end

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic idle_line(input int n);
    repeat (n) begin @(negedge clk); rx = 1'b1; end
  endtask

  task automatic drive_bit(input logic v);
    repeat (OVS) begin @(negedge clk); rx = v; end
  endtask

  task automatic send_frame(input logic [7:0] data, input logic stop_v);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(data[i]);
    drive_bit(stop_v);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 match_o after reset", int'(match_o), 0);
    check("R1 ferr_o after reset", int'(ferr_o), 0);
  endtask

  task automatic t_match;
    int p0 = pulses;
    send_frame(TRIG, 1'b1);
    idle_line(2*OVS);
    check("R4 trigger pulse count", pulses - p0, 1);
    check("R4 pulse width single cycle", wide, 0);
  endtask

  task automatic t_mismatch;
    int p0 = pulses;
    send_frame(TRIG ^ 8'h01, 1'b1); idle_line(2*OVS);
    check("R3 bit0 differs", pulses - p0, 0);
    send_frame(TRIG ^ 8'h80, 1'b1); idle_line(2*OVS);
    check("R3 bit7 differs", pulses - p0, 0);
    send_frame({<<{TRIG}}, 1'b1); idle_line(2*OVS);
    check("R3 bit-reversed byte", pulses - p0, 0);
  endtask

  task automatic t_spike;
    int p0 = pulses;
    repeat (OVS/2 - 2) begin @(negedge clk); rx = 1'b0; end
    idle_line(3*OVS);
    check("R2 spike gives no error", int'(ferr_o), 0);
    send_frame(TRIG, 1'b1); idle_line(2*OVS);
    check("R2 frame after spike", pulses - p0, 1);
  endtask

  task automatic t_wait_resync;
    int p0 = pulses;
    send_frame(8'h00, 1'b1);
    send_frame(TRIG, 1'b1);
    idle_line(2*OVS);
    check("R5 resync after mismatch", pulses - p0, 1);
  endtask

  task automatic t_badstop;
    int p0 = pulses;
    send_frame(TRIG, 1'b0);
    @(negedge clk); rx = 1'b1;
    check("R6 ferr set on low stop", int'(ferr_o), 1);
    check("R6 no match on low stop", pulses - p0, 0);
    idle_line(2*OVS);
    check("R6 ferr cleared after high", int'(ferr_o), 0);
    send_frame(TRIG, 1'b1); idle_line(2*OVS);
    check("R6 recovery match", pulses - p0, 1);
    send_frame(8'hFF, 1'b0);
    @(negedge clk); rx = 1'b1;
    check("R6 ferr on mismatching data", int'(ferr_o), 1);
    idle_line(2*OVS);
  endtask

  task automatic t_back2back;
    int p0 = pulses;
    send_frame(TRIG, 1'b1);
    send_frame(TRIG, 1'b1);
    send_frame(TRIG, 1'b1);
    idle_line(2*OVS);
    check("R8 back-to-back pulses", pulses - p0, 3);
    check("R7 R4 width over bursts", wide, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rx = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle_line(2*OVS);
    t_reset();
    t_match();
    t_mismatch();
    t_spike();
    t_wait_resync();
    t_badstop();
    t_back2back();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule